// File: doc/BRIEF.md
# Two-Wire Bus Clock Rate Generator

This block turns the system clock into the bus clock timing for a two-wire bus master. A chain of cascaded counters divides the system clock by a programmable half-period count, then by a power of two, then by a programmable modulus, then by a fixed factor of ten. The chain produces one strobe per quarter of a bus clock bit, and a free-running bus clock level that the byte engine drives onto the open-drain line. One bus clock period lasts `20 * U` system cycles, where `U = (HP + 1) * 2^N * (M + 1)`. This gives a bus clock frequency of `fsys / (2*(HP+1)) / 2^N / (M+1) / 10`.

Software sets the divider values through two write ports. The first is an 8-bit half-period field. The second is a clock-control word that packs the modulus and the exponent. Writes are held in shadow copies. The active divider picks them up only at the next bus clock falling edge, so a running period is never cut short or stretched by reprogramming.

The generator watches the sensed line. While it has released the clock high but a target is still holding the line low, every counter freezes, which implements clock stretching. While the bus enable is clear, the whole chain is held cleared and the clock is left released.

Top module: `scl_rate_gen`

## Requirements
- R1: While `rst_n` is low or `bus_en` is low, `scl_out` is 1 (released) and `qtick` is 0.
- R2: While running without stretching, consecutive `qtick` pulses are exactly `5*U` cycles apart, with `U = (HP+1) * 2^N * (M+1)`.
- R3: Each bus clock period is `10*U` cycles low followed by `10*U` cycles high. Every change of `scl_out` from running coincides with a `qtick` pulse.
- R4: After `bus_en` rises, `scl_out` stays released. The first `qtick` follows `5*U` rising edges later, and the first fall of `scl_out` follows `10*U` edges after the enable.
- R5: The clock-control word `cc_wdata` carries the modulus M in bits 6:3 and the exponent N in bits 2:0.
- R6: A half-period value written below 5 behaves as 5. Values 5 to 255 are used as written.
- R7: A modulus written as 0 or 1 behaves as 2.
- R8: Out of reset, HP is 0x18, M is 2 and N is 0, so `qtick` pulses are 375 cycles apart.
- R9: A field write while running leaves the current period unchanged. The new values govern the period that starts at the next fall of `scl_out`.
- R10: While `scl_out` is 1 and `scl_in` is 0, all counting freezes and no `qtick` occurs. The period grows by exactly the number of held cycles.
- R11: Clearing `bus_en` mid-period releases the clock on the next edge. Re-enabling restarts timing from the start of R4.
- R12: `qtick` is high for exactly one cycle per pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus enable; low holds the divider cleared |
| hp_wr | input | 1 | Write strobe for the half-period field |
| hp_wdata | input | 8 | Half-period value HP |
| cc_wr | input | 1 | Write strobe for the clock-control word |
| cc_wdata | input | 7 | M in bits 6:3, N in bits 2:0 |
| scl_in | input | 1 | Sensed, already synchronous bus clock line |
| qtick | output | 1 | One-cycle quarter-bit strobe |
| scl_out | output | 1 | Bus clock level, 1 = released, 0 = drive low |

## Verification
The assertions assume that `scl_in` is already synchronous to `clk`, and that it reads low whenever the block itself drives low, as a wired-AND line does. They also assume that a stretching target eventually releases the line. The bench models the line as `scl_out` ANDed with a target hold signal, so the sensed level never reads high against a low drive. Every hold the bench applies falls inside a high phase and is released after a bounded count. Field writes are single-cycle strobes on either side of the enable. This covers both the direct loading path, taken while the bus is disabled, and the boundary loading path, taken while it runs.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  // Fixed final divider and quarter structure of one bus clock bit.
  localparam int unsigned FIXED_DIV = 10;
  localparam int unsigned QUARTERS  = 4;
  localparam int unsigned SUBS_PER_Q = (2 * FIXED_DIV) / QUARTERS;

  // Quarter index: bit 1 set means the clock is released high.
  typedef enum logic [1:0] {
    Q_LOW_A  = 2'd0,
    Q_LOW_B  = 2'd1,
    Q_HIGH_A = 2'd2,
    Q_HIGH_B = 2'd3
  } scl_quarter_e;
endpackage

// File: rtl/scl_cnt_stage.sv
module scl_cnt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = adv && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (adv)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int HP_W   = 8,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int HP_MIN = 5,
  parameter int M_MIN  = 2,
  parameter int HP_RST = 24,
  parameter int M_RST  = 2,
  parameter int N_RST  = 0,
  localparam int CC_W  = M_W + N_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bound,
  input  logic            hp_wr,
  input  logic [HP_W-1:0] hp_wdata,
  input  logic            cc_wr,
  input  logic [CC_W-1:0] cc_wdata,
  output logic [HP_W-1:0] act_hp,
  output logic [M_W-1:0]  act_m,
  output logic [N_W-1:0]  act_n
);
  logic [HP_W-1:0] sh_hp;
  logic [M_W-1:0]  sh_m;
  logic [N_W-1:0]  sh_n;
  logic [M_W-1:0]  m_field;
  logic [N_W-1:0]  n_field;

  assign m_field = cc_wdata[N_W +: M_W];
  assign n_field = cc_wdata[N_W-1:0];

  // Shadow copies, clamped to the legal floor on write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hp <= HP_W'(HP_RST);
      sh_m  <= M_W'(M_RST);
      sh_n  <= N_W'(N_RST);
    end else begin
      if (hp_wr) sh_hp <= (hp_wdata < HP_W'(HP_MIN)) ? HP_W'(HP_MIN) : hp_wdata;
      if (cc_wr) begin
        sh_m <= (m_field < M_W'(M_MIN)) ? M_W'(M_MIN) : m_field;
        sh_n <= n_field;
      end
    end
  end

  // Active copies follow the shadow while idle, else only at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hp <= HP_W'(HP_RST);
      act_m  <= M_W'(M_RST);
      act_n  <= N_W'(N_RST);
    end else if (!bus_en || bound) begin
      act_hp <= sh_hp;
      act_m  <= sh_m;
      act_n  <= sh_n;
    end
  end

  a_r6_hp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    act_hp >= HP_W'(HP_MIN));
  a_r7_m_floor: assert property (@(posedge clk) disable iff (!rst_n)
    act_m >= M_W'(M_MIN));
  a_r9_cfg_frozen_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bound) |=> ($stable(act_hp) && $stable(act_m) && $stable(act_n)));
endmodule

// File: rtl/scl_div_chain.sv
module scl_div_chain #(
  parameter int HP_W = 8,
  parameter int M_W  = 4,
  parameter int N_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            hold,
  input  logic [HP_W-1:0] act_hp,
  input  logic [M_W-1:0]  act_m,
  input  logic [N_W-1:0]  act_n,
  output logic            step
);
  localparam int NC_W = (1 << N_W) - 1;

  logic            adv;
  logic            clr;
  logic [NC_W:0]   n_span;
  logic [NC_W:0]   n_span_m1;
  logic [NC_W-1:0] n_lim;
  logic [HP_W-1:0] hp_cnt;
  logic [NC_W-1:0] n_cnt;
  logic [M_W-1:0]  m_cnt;
  logic            hp_wrap;
  logic            n_wrap;

  assign adv       = run && !hold;
  assign clr       = !run;
  assign n_span    = (NC_W+1)'(1) << act_n;
  assign n_span_m1 = n_span - (NC_W+1)'(1);
  assign n_lim     = n_span_m1[NC_W-1:0];

  scl_cnt_stage #(.W(HP_W)) u_hp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .lim(act_hp), .cnt(hp_cnt), .wrap(hp_wrap));

  scl_cnt_stage #(.W(NC_W)) u_pow (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(hp_wrap),
    .lim(n_lim), .cnt(n_cnt), .wrap(n_wrap));

  scl_cnt_stage #(.W(M_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(n_wrap),
    .lim(act_m), .cnt(m_cnt), .wrap(step));

  a_r10_counts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> ($stable(hp_cnt) && $stable(n_cnt) && $stable(m_cnt)));
  a_r10_no_step_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !step);
  a_r11_cleared_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hp_cnt == '0 && n_cnt == '0 && m_cnt == '0));
endmodule

// File: rtl/scl_phase.sv
module scl_phase
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  output logic qtick,
  output logic scl_out,
  output logic bound
);
  localparam int SUB_W = $clog2(SUBS_PER_Q);

  logic [SUB_W-1:0] sub_cnt;
  logic             q_adv;
  scl_quarter_e     q;
  logic [1:0]       q_nxt;

  scl_cnt_stage #(.W(SUB_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .clr(!run), .adv(step),
    .lim(SUB_W'(SUBS_PER_Q - 1)), .cnt(sub_cnt), .wrap(q_adv));

  assign q_nxt = q + 2'd1;
  assign bound = q_adv && (q == Q_HIGH_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= Q_HIGH_A;
      scl_out <= 1'b1;
      qtick   <= 1'b0;
    end else if (!run) begin
      q       <= Q_HIGH_A;
      scl_out <= 1'b1;
      qtick   <= 1'b0;
    end else begin
      qtick <= q_adv;
      if (q_adv) begin
        q       <= scl_quarter_e'(q_nxt);
        scl_out <= q_nxt[1];
      end
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_out && !qtick));
  a_r12_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick);
  a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> qtick);
  a_r2_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub_cnt <= SUB_W'(SUBS_PER_Q - 1));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int HP_W   = 8,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int HP_MIN = 5,
  parameter int M_MIN  = 2,
  parameter int HP_RST = 24,
  parameter int M_RST  = 2,
  parameter int N_RST  = 0,
  localparam int CC_W  = M_W + N_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            hp_wr,
  input  logic [HP_W-1:0] hp_wdata,
  input  logic            cc_wr,
  input  logic [CC_W-1:0] cc_wdata,
  input  logic            scl_in,
  output logic            qtick,
  output logic            scl_out
);
  logic [HP_W-1:0] act_hp;
  logic [M_W-1:0]  act_m;
  logic [N_W-1:0]  act_n;
  logic            bound;
  logic            step;
  logic            stretch;

  // Released high but line still low: a target is stretching the clock.
  assign stretch = scl_out && !scl_in;

  scl_cfg_regs #(
    .HP_W(HP_W), .M_W(M_W), .N_W(N_W), .HP_MIN(HP_MIN), .M_MIN(M_MIN),
    .HP_RST(HP_RST), .M_RST(M_RST), .N_RST(N_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bound(bound),
    .hp_wr(hp_wr), .hp_wdata(hp_wdata), .cc_wr(cc_wr), .cc_wdata(cc_wdata),
    .act_hp(act_hp), .act_m(act_m), .act_n(act_n));

  scl_div_chain #(.HP_W(HP_W), .M_W(M_W), .N_W(N_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .run(bus_en), .hold(stretch),
    .act_hp(act_hp), .act_m(act_m), .act_n(act_n), .step(step));

  scl_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(bus_en), .step(step),
    .qtick(qtick), .scl_out(scl_out), .bound(bound));

  a_r10_no_tick_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && stretch) |=> !qtick);
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic       hp_wr = 1'b0;
  logic [7:0] hp_wdata = '0;
  logic       cc_wr = 1'b0;
  logic [6:0] cc_wdata = '0;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       qtick;
  logic       scl_out;
  int         cyc = 0;
  int         tests = 0;
  int         fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Wired-AND line: low when the block drives low or a target holds it.
  assign scl_in = scl_out & ~slave_hold;

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .hp_wr(hp_wr),
    .hp_wdata(hp_wdata), .cc_wr(cc_wr), .cc_wdata(cc_wdata),
    .scl_in(scl_in), .qtick(qtick), .scl_out(scl_out));

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_u(int hp, int m, int n);
    int h = (hp < 5) ? 5 : hp;
    int mm = (m < 2) ? 2 : m;
    return (h + 1) * (1 << n) * (mm + 1);
  endfunction

  task automatic write_hp(logic [7:0] d);
    @(negedge clk); hp_wr = 1'b1; hp_wdata = d;
    @(negedge clk); hp_wr = 1'b0;
  endtask

  task automatic write_cc(logic [6:0] d);
    @(negedge clk); cc_wr = 1'b1; cc_wdata = d;
    @(negedge clk); cc_wr = 1'b0;
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!qtick);
    t = cyc;
  endtask

  task automatic wait_level(logic lv, output int t);
    while (scl_out == lv) @(negedge clk);
    while (scl_out != lv) @(negedge clk);
    t = cyc;
  endtask

  // Enable and measure first tick, first fall, low/high times and spacing.
  task automatic measure(int u, string tag);
    int c0, t0, f0, r0, f1, t1;
    @(negedge clk); bus_en = 1'b1; c0 = cyc;
    wait_tick(t0);
    chk({tag, " R4 first tick"}, t0 - c0, 5 * u);
    chk({tag, " R4 released at first tick"}, int'(scl_out), 1);
    @(negedge clk);
    chk({tag, " R12 tick width"}, int'(qtick), 0);
    wait_level(1'b0, f0);
    chk({tag, " R4 first fall"}, f0 - c0, 10 * u);
    chk({tag, " R3 tick at fall"}, int'(qtick), 1);
    wait_level(1'b1, r0);
    chk({tag, " R3 low time"}, r0 - f0, 10 * u);
    wait_level(1'b0, f1);
    chk({tag, " R3 high time"}, f1 - r0, 10 * u);
    wait_tick(t1);
    chk({tag, " R2 tick spacing"}, t1 - f1, 5 * u);
  endtask

  task automatic cfg_measure(int hp, int m, int n, string tag);
    @(negedge clk); bus_en = 1'b0;
    write_hp(8'(hp));
    write_cc(7'((m << 3) | n));
    @(negedge clk);
    measure(exp_u(hp, m, n), tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int f0, f1, f2, r0, t0, c0;
    int hps[3] = '{5, 6, 9};
    repeat (3) @(negedge clk);
    chk("R1 reset scl", int'(scl_out), 1);
    chk("R1 reset tick", int'(qtick), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 disabled scl", int'(scl_out), 1);

    // R8: reset values, HP=24 M=2 N=0
    measure(exp_u(24, 2, 0), "R8 reset fields");
    chk("R8 unit", exp_u(24, 2, 0) * 5, 375);

    // Sweep over a small grid of divider settings (R2, R3, R4, R5)
    foreach (hps[i]) begin
      for (int m = 2; m <= 3; m++) begin
        for (int n = 0; n <= 1; n++) begin
          cfg_measure(hps[i], m, n, "R5 sweep");
        end
      end
    end
    cfg_measure(5, 2, 3, "R5 exponent 3");
    cfg_measure(6, 15, 0, "R5 modulus 15");
    cfg_measure(2, 2, 0, "R6 hp below floor");
    cfg_measure(0, 3, 0, "R6 hp zero");
    cfg_measure(5, 0, 0, "R7 modulus 0");
    cfg_measure(5, 1, 1, "R7 modulus 1");

    // R9: reprogram mid-period (U 18 -> 40)
    cfg_measure(5, 2, 0, "R9 base");
    wait_level(1'b0, f0);
    repeat (50) @(negedge clk);
    write_hp(8'd9);
    write_cc(7'(3 << 3));
    wait_level(1'b0, f1);
    chk("R9 current period kept", f1 - f0, 20 * 18);
    wait_level(1'b0, f2);
    chk("R9 next period new", f2 - f1, 20 * 40);

    // R10: stretch 37 cycles inside the high phase (U=40)
    wait_level(1'b0, f0);
    wait_level(1'b1, r0);
    slave_hold = 1'b1;
    for (int k = 0; k < 37; k++) begin
      @(negedge clk);
      chk("R10 no tick while held", int'(qtick), 0);
    end
    slave_hold = 1'b0;
    wait_level(1'b0, f1);
    chk("R10 stretched period", f1 - f0, 20 * 40 + 37);
    wait_level(1'b0, f2);
    chk("R10 following period", f2 - f1, 20 * 40);

    // R11: disable while driving low, then re-enable
    repeat (20) @(negedge clk);
    chk("R11 low before disable", int'(scl_out), 0);
    bus_en = 1'b0;
    @(negedge clk);
    chk("R11 released", int'(scl_out), 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R1 idle tick", int'(qtick), 0);
      chk("R1 idle scl", int'(scl_out), 1);
    end
    bus_en = 1'b1; c0 = cyc;
    wait_tick(t0);
    chk("R11 restart first tick", t0 - c0, 5 * 40);

    summary();
    $finish;
  end
endmodule